// File: doc/BRIEF.md
# Low-Power Sleep Mode Controller

This block decides how deeply the processor powers down when a sleep instruction retires, and brings it back to full operation when it is woken. At the moment the sleep strobe is accepted, the block looks at a selector bit in each of two standby control words. Those two bits give three possible depths. Each depth gates a different set of clocks: the CPU clock alone, the DMA controller, or the timer unit and the serial port.

The standby depth does not cut the timer or serial clocks at once. Each of those two peripherals keeps its run enable until its busy flag reports that its outstanding work is done. After that its enable stays low until wakeup. Any pending interrupt, or a reset, returns the block straight to the running state from whichever depth it was in, and every enable comes back in the same cycle.

Top module: `pwrdn_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, `pm_state` reads 0 (running) and all four enables are high. Reset also wakes the block from any sleep depth.
- R2: A `sleep_req` taken while running, with bit 7 of `stby_ctrl_a` set, moves `pm_state` to 3 (standby) on the next clock edge, whatever `stby_ctrl_b` holds.
- R3: A `sleep_req` taken while running, with bit 7 of `stby_ctrl_a` clear and bit 7 of `stby_ctrl_b` set, moves `pm_state` to 2 (deep sleep).
- R4: A `sleep_req` taken while running, with bit 7 of both control words clear, moves `pm_state` to 1 (plain sleep).
- R5: `cpu_clk_en` is high exactly when `pm_state` is 0.
- R6: In plain sleep, `dma_run_en`, `tmr_run_en` and `ser_run_en` all stay high.
- R7: In deep sleep, `dma_run_en` is low while `tmr_run_en` and `ser_run_en` stay high.
- R8: In standby, `dma_run_en` stays high. Each of `tmr_run_en` and `ser_run_en` drops one cycle after a clock edge at which the block is in standby and that peripheral's busy input is low. Once dropped, it stays low until the block leaves standby, and the two drop independently.
- R9: With `irq_pending` high in any sleep depth, `pm_state` returns to 0 on the next edge, and all enables are high in that same cycle.
- R10: A `sleep_req` while the block is not running is ignored: the state and the enables do not change.
- R11: The control words are sampled only in the cycle a sleep request is taken. Only bit 7 of each word is decoded, so the other bits and any later changes have no effect.
- R12: `irq_pending` while running leaves `pm_state` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | One-cycle strobe from a retiring sleep instruction |
| stby_ctrl_a | input | 8 | First standby control word (bit 7 selects standby) |
| stby_ctrl_b | input | 8 | Second standby control word (bit 7 selects deep sleep) |
| irq_pending | input | 1 | An interrupt is pending (wake source) |
| tmr_busy | input | 1 | Timer unit still has work in flight |
| ser_busy | input | 1 | Serial port still has work in flight |
| pm_state | output | 2 | 0 running, 1 sleep, 2 deep sleep, 3 standby |
| cpu_clk_en | output | 1 | CPU clock enable |
| dma_run_en | output | 1 | DMA controller run enable |
| tmr_run_en | output | 1 | Timer unit run enable |
| ser_run_en | output | 1 | Serial port run enable |

## Verification
The depth decode is driven with all four values of the two selector bits, including both bits set, to confirm that the standby bit takes priority. It is also driven with every other bit of both words set and the selector bits clear, which shows that only bit 7 is decoded. Standby entry is tried with both peripherals idle and with one of them busy for several cycles. These runs separate a drop on entry from a drop after draining, and show that the two peripherals drop independently and that an enable stays low once it has dropped. Wakeup is tried from every depth, by interrupt and by reset. Sleep strobes and control-word changes issued while asleep, and interrupts issued while running, confirm that those inputs are ignored.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
   typedef enum logic [1:0] {
      PM_RUN   = 2'd0,
      PM_SLEEP = 2'd1,
      PM_DEEP  = 2'd2,
      PM_STBY  = 2'd3
   } pm_state_t;
endpackage

// File: rtl/pwrdn_depth_sel.sv
module pwrdn_depth_sel
   import pwrdn_pkg::*;
#(
   parameter int CTRL_W   = 8,
   parameter int STBY_BIT = 7,
   parameter int DEEP_BIT = 7
) (
   input  logic [CTRL_W-1:0] ctrl_a,
   input  logic [CTRL_W-1:0] ctrl_b,
   output pm_state_t         target
);
   generate
      if (STBY_BIT >= CTRL_W || STBY_BIT < 0) begin : g_bad_stby
         $error("STBY_BIT outside control word");
      end
      if (DEEP_BIT >= CTRL_W || DEEP_BIT < 0) begin : g_bad_deep
         $error("DEEP_BIT outside control word");
      end
   endgenerate

   logic sel_stby;
   logic sel_deep;
   assign sel_stby = ctrl_a[STBY_BIT];
   assign sel_deep = ctrl_b[DEEP_BIT];

   // standby selector outranks the deep-sleep selector
   always_comb begin
      if (sel_stby)      target = PM_STBY;
      else if (sel_deep) target = PM_DEEP;
      else               target = PM_SLEEP;
   end
endmodule

// File: rtl/pwrdn_fsm.sv
module pwrdn_fsm
   import pwrdn_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sleep_req,
   input  logic      irq_pending,
   input  pm_state_t target,
   output pm_state_t state
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= PM_RUN;
      end else begin
         case (state)
            PM_RUN:  if (sleep_req)   state <= target;
            default: if (irq_pending) state <= PM_RUN;
         endcase
      end
   end

   // R10
   sleep_while_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != PM_RUN && !irq_pending) |=> $stable(state));

   // R9
   irq_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != PM_RUN && irq_pending) |=> state == PM_RUN);

   // R12
   irq_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_RUN && !sleep_req) |=> state == PM_RUN);
endmodule

// File: rtl/pwrdn_gate.sv
module pwrdn_gate
   import pwrdn_pkg::*;
#(
   parameter int NUM_DRAIN  = 2,
   parameter bit DRAIN_WAIT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  pm_state_t            state,
   input  logic [NUM_DRAIN-1:0] drain_busy,
   output logic                 cpu_clk_en,
   output logic                 dma_run_en,
   output logic [NUM_DRAIN-1:0] drain_run_en
);
   generate
      if (NUM_DRAIN < 1) begin : g_bad_num
         $error("NUM_DRAIN must be at least one");
      end
   endgenerate

   logic in_stby;
   assign in_stby    = (state == PM_STBY);
   assign cpu_clk_en = (state == PM_RUN);
   assign dma_run_en = (state != PM_DEEP);

   generate
      for (genvar i = 0; i < NUM_DRAIN; i++) begin : g_drain
         logic halted;
         logic idle;
         if (DRAIN_WAIT) begin : g_wait
            assign idle = !drain_busy[i];
         end else begin : g_nowait
            assign idle = 1'b1;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                halted <= 1'b0;
            else if (!in_stby)         halted <= 1'b0;
            else if (idle)             halted <= 1'b1;
         end

         assign drain_run_en[i] = !(in_stby && halted);

         // R8
         drain_only_stby_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !drain_run_en[i] |-> state == PM_STBY);

         // R8
         drain_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!drain_run_en[i] && state == PM_STBY) |=> (state != PM_STBY || !drain_run_en[i]));
      end
   endgenerate
endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
   import pwrdn_pkg::*;
#(
   parameter int CTRL_W   = 8,
   parameter int STBY_BIT = 7,
   parameter int DEEP_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep_req,
   input  logic [CTRL_W-1:0] stby_ctrl_a,
   input  logic [CTRL_W-1:0] stby_ctrl_b,
   input  logic              irq_pending,
   input  logic              tmr_busy,
   input  logic              ser_busy,
   output logic [1:0]        pm_state,
   output logic              cpu_clk_en,
   output logic              dma_run_en,
   output logic              tmr_run_en,
   output logic              ser_run_en
);
   localparam int NUM_DRAIN = 2;

   pm_state_t            target;
   pm_state_t            state;
   logic [NUM_DRAIN-1:0] busy_vec;
   logic [NUM_DRAIN-1:0] run_vec;

   assign busy_vec = {ser_busy, tmr_busy};

   pwrdn_depth_sel #(
      .CTRL_W  (CTRL_W),
      .STBY_BIT(STBY_BIT),
      .DEEP_BIT(DEEP_BIT)
   ) u_sel (
      .ctrl_a(stby_ctrl_a),
      .ctrl_b(stby_ctrl_b),
      .target(target)
   );

   pwrdn_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .sleep_req  (sleep_req),
      .irq_pending(irq_pending),
      .target     (target),
      .state      (state)
   );

   pwrdn_gate #(
      .NUM_DRAIN (NUM_DRAIN),
      .DRAIN_WAIT(1'b1)
   ) u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .state       (state),
      .drain_busy  (busy_vec),
      .cpu_clk_en  (cpu_clk_en),
      .dma_run_en  (dma_run_en),
      .drain_run_en(run_vec)
   );

   assign pm_state   = state;
   assign tmr_run_en = run_vec[0];
   assign ser_run_en = run_vec[1];

   // R7
   deep_gates_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state == PM_DEEP |-> (!dma_run_en && tmr_run_en && ser_run_en));

   // R6
   plain_keeps_periph_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state == PM_SLEEP |-> (dma_run_en && tmr_run_en && ser_run_en));

   // R2
   stby_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_RUN && sleep_req && stby_ctrl_a[STBY_BIT]) |=> state == PM_STBY);
endmodule

// File: tb/test_pwrdn_ctrl.sv
module test_pwrdn_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sleep_req = 1'b0;
   logic [7:0] ctrl_a = 8'h00;
   logic [7:0] ctrl_b = 8'h00;
   logic       irq = 1'b0;
   logic       tbusy = 1'b0;
   logic       sbusy = 1'b0;
   logic [1:0] st;
   logic       cpu_en, dma_en, tmr_en, ser_en;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pwrdn_ctrl i_pwrdn_ctrl (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
      .stby_ctrl_a(ctrl_a), .stby_ctrl_b(ctrl_b), .irq_pending(irq),
      .tmr_busy(tbusy), .ser_busy(sbusy), .pm_state(st),
      .cpu_clk_en(cpu_en), .dma_run_en(dma_en),
      .tmr_run_en(tmr_en), .ser_run_en(ser_en)
   );

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // {state, cpu, dma, tmr, ser}
   function automatic logic [7:0] snap();
      return {2'b00, st, cpu_en, dma_en, tmr_en, ser_en};
   endfunction

   function automatic logic [7:0] expv(logic [1:0] s, logic c, logic d, logic t, logic r);
      return {2'b00, s, c, d, t, r};
   endfunction

   task automatic req_sleep(logic [7:0] a, logic [7:0] b);
      @(negedge clk);
      ctrl_a = a; ctrl_b = b; sleep_req = 1'b1;
      @(negedge clk);
      sleep_req = 1'b0; ctrl_a = 8'h00; ctrl_b = 8'h00;
   endtask

   task automatic wake_irq(string req);
      @(negedge clk);
      irq = 1'b1;
      @(negedge clk);
      irq = 1'b0;
      check(req, snap(), expv(2'd0, 1, 1, 1, 1));
   endtask

   task automatic t_reset();
      #1;
      check("R1 during reset", snap(), expv(2'd0, 1, 1, 1, 1));
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", snap(), expv(2'd0, 1, 1, 1, 1));
   endtask

   task automatic t_plain();
      req_sleep(8'h00, 8'h00);
      check("R4 R5 R6 plain sleep", snap(), expv(2'd1, 0, 1, 1, 1));
      wake_irq("R9 wake from plain");
   endtask

   task automatic t_deep();
      req_sleep(8'h00, 8'h80);
      check("R3 R7 deep sleep", snap(), expv(2'd2, 0, 0, 1, 1));
      wake_irq("R9 wake from deep");
   endtask

   task automatic t_standby_idle();
      req_sleep(8'h80, 8'h80);
      check("R2 standby entry", snap(), expv(2'd3, 0, 1, 1, 1));
      @(negedge clk);
      check("R8 idle drop", snap(), expv(2'd3, 0, 1, 0, 0));
      wake_irq("R9 wake from standby");
   endtask

   task automatic t_standby_drain();
      tbusy = 1'b1;
      req_sleep(8'h80, 8'h00);
      @(negedge clk);
      check("R8 serial drops, timer busy", snap(), expv(2'd3, 0, 1, 1, 0));
      repeat (3) @(negedge clk);
      check("R8 timer held while busy", snap(), expv(2'd3, 0, 1, 1, 0));
      tbusy = 1'b0;
      @(negedge clk);
      check("R8 timer drops after drain", snap(), expv(2'd3, 0, 1, 0, 0));
      tbusy = 1'b1; sbusy = 1'b1;
      @(negedge clk);
      check("R8 stays low once dropped", snap(), expv(2'd3, 0, 1, 0, 0));
      tbusy = 1'b0; sbusy = 1'b0;
      wake_irq("R9 wake from drained standby");
   endtask

   task automatic t_ignore_sleep();
      req_sleep(8'h00, 8'h00);
      req_sleep(8'h80, 8'h80);
      check("R10 sleep while asleep", snap(), expv(2'd1, 0, 1, 1, 1));
      @(negedge clk);
      ctrl_a = 8'h80; ctrl_b = 8'h80;
      repeat (2) @(negedge clk);
      check("R11 late ctrl change", snap(), expv(2'd1, 0, 1, 1, 1));
      ctrl_a = 8'h00; ctrl_b = 8'h00;
      wake_irq("R9 wake after ignored request");
   endtask

   task automatic t_other_bits();
      req_sleep(8'h7F, 8'h7F);
      check("R11 non-selector bits", snap(), expv(2'd1, 0, 1, 1, 1));
      wake_irq("R9 wake after other bits");
   endtask

   task automatic t_irq_running();
      @(negedge clk);
      irq = 1'b1;
      repeat (2) @(negedge clk);
      irq = 1'b0;
      check("R12 irq while running", snap(), expv(2'd0, 1, 1, 1, 1));
   endtask

   task automatic t_reset_wake();
      req_sleep(8'h00, 8'h80);
      check("R3 deep before reset", snap(), expv(2'd2, 0, 0, 1, 1));
      rst_n = 1'b0;
      #1;
      check("R1 reset wakes", snap(), expv(2'd0, 1, 1, 1, 1));
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      t_reset();
      t_plain();
      t_deep();
      t_standby_idle();
      t_standby_drain();
      t_ignore_sleep();
      t_other_bits();
      t_irq_running();
      t_reset_wake();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule